// File: doc/BRIEF.md
# Serial-Peripheral Register Access Bridge

This block lets an external microcontroller, acting as SPI master, read and write an on-chip byte-addressed register space. Each transaction is framed by chip select. It opens with a header of two or three bytes that carries a start address and a command, and continues with a data phase of any length. During the data phase the bridge either fetches bytes from the register space and shifts them out, or collects bytes from the master and writes them in. After every data byte the working address moves up by one.

The serial pins are oversampled with the system clock through a synchronizer, so the block needs no clock of its own. The serial clock must be slow enough that each half period spans several system clocks. Several things are fixed by static configuration inputs: the active level of chip select, the active level of the interrupt output, the clock polarity and phase, and whether the header is in short or extended form. On the register side there is a simple synchronous master port. Read data is expected one cycle after the read strobe.

Top module: `spi_regbridge`

## Requirements
- R1: `active` is high while chip select is at its configured active level (`cfg_sel_high` = 0 means a low pin is active, 1 means a high pin is active), and low otherwise.
- R2: In short header mode (`cfg_ext_addr` = 0) the header is two bytes. Byte 0 holds address bits 12:5, byte 1 bits 7:3 hold address bits 4:0, and byte 1 bits 2:0 hold the command. Command 3'b010 is a read and 3'b100 is a write. Any other command, including 3'b000, produces no strobes for the whole frame.
- R3: In extended header mode (`cfg_ext_addr` = 1) the header is three bytes. Byte 1 bits 2:0 must equal 3'b110, or the frame produces no strobes. Byte 2 bits 7:5 hold address bits 15:13 and byte 2 bits 4:2 hold the command, which uses the same codes as R2.
- R4: In a write frame, every complete data byte gives exactly one `reg_wr` pulse carrying that byte. The first pulse goes to the start address and each later pulse goes to the previous address plus one.
- R5: A partial data byte of fewer than eight bits, left when chip select is released, is discarded with no strobe.
- R6: In a read frame, `reg_rd` pulses at the start address once the header is complete, and again at each following address during the last bit of every data byte. Data byte k on MISO, sent MSB first, is the register content at start address + k.
- R7: MISO is 0 during the header, throughout a write frame, and while chip select is inactive.
- R8: All four clock modes work. MOSI is sampled on the leading edge of the serial clock when `cfg_cpha` = 0 and on the trailing edge when it is 1, with the idle level given by `cfg_cpol`.
- R9: `spi_irq` shows `irq_req` at the configured level (`cfg_irq_high` = 0 means active-low), one clock later.
- R10: Releasing chip select at any point, including mid-header, returns the header decoder to its first byte. The next frame is decoded from scratch.
- R11: `reg_wr` and `reg_rd` are never high together, and each pulse lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel_high | input | 1 | Chip select active level (1 = high) |
| cfg_irq_high | input | 1 | Interrupt output active level (1 = high) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = on trailing edge |
| cfg_ext_addr | input | 1 | 1 = three-byte header |
| spi_sclk | input | 1 | Serial clock from master |
| spi_sel | input | 1 | Chip select from master |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_irq | output | 1 | Interrupt to master |
| irq_req | input | 1 | Internal interrupt request, active high |
| active | output | 1 | Transaction in progress |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
A sampling edge on the pin takes two synchronizer stages and one edge-detect register to reach the shifter. A completed byte therefore produces its write strobe about four clocks after the edge, and read data lands in the MISO holding register about six clocks after the header's last edge. MISO changes about four clocks after the sampling edge that advances it. The bench holds each serial clock level for eight system clocks and reads MISO just before it toggles its own sampling edge, which lies eight to sixteen clocks after the last possible change. Strobes are logged by a register-file model in the bench, and their counts, addresses and data are compared only after chip select has been released and ten further clocks have passed. `active` and `spi_irq` are checked at least eight clocks after their input moves, well past their two- or one-cycle delay.

// File: rtl/spi_regbridge_pkg.sv
// Shared constants and types for the serial register bridge.
// Assumes byte-wide registers and a 16-bit register address space.
package spi_regbridge_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    // header command codes
    localparam logic [2:0] CMD_READ  = 3'b010;
    localparam logic [2:0] CMD_WRITE = 3'b100;
    localparam logic [2:0] CMD_EXT   = 3'b110;

    // frame phase
    typedef enum logic [1:0] {
        PH_HDR   = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2,
        PH_SKIP  = 2'd3
    } phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchronizer for asynchronous pins.
// Assumes each bit is sampled independently; reset value is all zeros,
// so callers must present inputs whose inactive level is 0 where it matters.
module spi_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // shift the pin vector through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
// Bit-level engine: finds the sampling edge of the synchronized serial
// clock for the configured mode, shifts MOSI into bytes and drives MISO
// from a held byte indexed by the bit counter.
// Assumes each serial clock half period spans several system clocks.
module spi_bit_engine
    import spi_regbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              sel_act,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_done,
    output logic              pre_last,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    logic                 sclk_prev;
    logic                 edge_rise;
    logic                 edge_fall;
    logic                 sample;
    logic [BIT_IDX_W-1:0] bit_cnt;
    logic [BYTE_W-2:0]    rx_sr;

    // remember the previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    // pick the sampling edge: rising when polarity equals phase
    always_comb begin
        edge_rise = sclk_s & ~sclk_prev;
        edge_fall = ~sclk_s & sclk_prev;
        sample    = sel_act & ((cfg_cpol == cfg_cpha) ? edge_rise : edge_fall);
    end

    // receive shifter, bit counter and byte-boundary pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
            pre_last  <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            pre_last  <= 1'b0;
            if (!sel_act) begin
                bit_cnt <= '0;
                rx_sr   <= '0;
            end else if (sample) begin
                bit_cnt <= bit_cnt + 1'b1;
                rx_sr   <= {rx_sr[BYTE_W-3:0], mosi_s};
                if (bit_cnt == BIT_IDX_W'(BYTE_W - 1)) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sr, mosi_s};
                end
                if (bit_cnt == BIT_IDX_W'(BYTE_W - 2)) pre_last <= 1'b1;
            end
        end
    end

    // present the current bit of the held byte, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n) miso <= 1'b0;
        else        miso <= sel_act & tx_byte[~bit_cnt];
    end
endmodule

// File: rtl/spi_frame_ctrl.sv
// Frame controller: decodes the two- or three-byte header, then runs a
// read or write burst on the register port with an auto-incrementing
// address. Read data is expected one cycle after the read strobe.
// Assumes byte_done and pre_last are single-cycle pulses well apart.
module spi_frame_ctrl
    import spi_regbridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_act,
    input  logic              cfg_ext_addr,
    input  logic              byte_done,
    input  logic              pre_last,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd
);
    phase_e            phase;
    logic [1:0]        hdr_idx;
    logic [BYTE_W-1:0] hdr0;
    logic [4:0]        hdr1_hi;
    logic [BYTE_W-1:0] nxt_byte;
    logic              rd_pend;
    logic              tx_wait;
    logic              hdr_done;
    logic [ADDR_W-1:0] hdr_addr;
    logic [2:0]        hdr_cmd;

    // header completion and assembled address/command
    always_comb begin
        hdr_done = byte_done && (phase == PH_HDR) &&
                   (cfg_ext_addr ? (hdr_idx == 2'd2) : (hdr_idx == 2'd1));
        if (cfg_ext_addr) begin
            hdr_addr = {rx_byte[7:5], hdr0, hdr1_hi};
            hdr_cmd  = rx_byte[4:2];
        end else begin
            hdr_addr = {3'b000, hdr0, rx_byte[7:3]};
            hdr_cmd  = rx_byte[2:0];
        end
    end

    // phase sequencing, strobes, address counter and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_HDR;
            hdr_idx   <= '0;
            hdr0      <= '0;
            hdr1_hi   <= '0;
            nxt_byte  <= '0;
            tx_byte   <= '0;
            rd_pend   <= 1'b0;
            tx_wait   <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
        end else begin
            reg_wr  <= 1'b0;
            reg_rd  <= 1'b0;
            rd_pend <= reg_rd;
            if (reg_wr || reg_rd) reg_addr <= reg_addr + 16'd1;

            if (rd_pend) begin
                if (tx_wait) begin
                    tx_byte <= reg_rdata;
                    tx_wait <= 1'b0;
                end else begin
                    nxt_byte <= reg_rdata;
                end
            end

            if (byte_done) begin
                case (phase)
                    PH_HDR: begin
                        if (hdr_idx == 2'd0) begin
                            hdr0    <= rx_byte;
                            hdr_idx <= 2'd1;
                        end else if (hdr_idx == 2'd1) begin
                            hdr1_hi <= rx_byte[7:3];
                            hdr_idx <= 2'd2;
                            if (cfg_ext_addr && rx_byte[2:0] != CMD_EXT) phase <= PH_SKIP;
                        end
                        if (hdr_done) begin
                            reg_addr <= hdr_addr;
                            if (hdr_cmd == CMD_READ) begin
                                phase   <= PH_READ;
                                reg_rd  <= 1'b1;
                                tx_wait <= 1'b1;
                            end else if (hdr_cmd == CMD_WRITE) begin
                                phase <= PH_WRITE;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                    end
                    PH_WRITE: begin
                        reg_wr    <= 1'b1;
                        reg_wdata <= rx_byte;
                    end
                    PH_READ: tx_byte <= nxt_byte;
                    default: ;
                endcase
            end

            if (pre_last && phase == PH_READ && sel_act) reg_rd <= 1'b1;

            if (!sel_act) begin
                phase   <= PH_HDR;
                hdr_idx <= '0;
                tx_byte <= '0;
                tx_wait <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_regbridge.sv
// Top of the serial register bridge: applies select polarity, synchronizes
// the pins, and connects the bit engine to the frame controller. Also
// drives the interrupt pin at its configured level.
// Assumes static configuration inputs, changed only while select is idle.
module spi_regbridge
    import spi_regbridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sel_high,
    input  logic        cfg_irq_high,
    input  logic        cfg_cpol,
    input  logic        cfg_cpha,
    input  logic        cfg_ext_addr,
    input  logic        spi_sclk,
    input  logic        spi_sel,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        spi_irq,
    input  logic        irq_req,
    output logic        active,
    output logic [15:0] reg_addr,
    output logic [7:0]  reg_wdata,
    output logic        reg_wr,
    output logic        reg_rd,
    input  logic [7:0]  reg_rdata
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0]  pins_raw;
    logic [PIN_W-1:0]  pins_s;
    logic              sel_act;
    logic              byte_done;
    logic              pre_last;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] tx_byte;

    // fold select polarity in before the synchronizer so reset reads idle
    assign pins_raw = {(cfg_sel_high ? spi_sel : ~spi_sel), spi_sclk, spi_mosi};

    spi_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    assign sel_act = pins_s[2];
    assign active  = sel_act;

    spi_bit_engine bit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .sel_act  (sel_act),
        .cfg_cpol (cfg_cpol),
        .cfg_cpha (cfg_cpha),
        .tx_byte  (tx_byte),
        .byte_done(byte_done),
        .pre_last (pre_last),
        .rx_byte  (rx_byte),
        .miso     (spi_miso)
    );

    spi_frame_ctrl frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_act     (sel_act),
        .cfg_ext_addr(cfg_ext_addr),
        .byte_done   (byte_done),
        .pre_last    (pre_last),
        .rx_byte     (rx_byte),
        .reg_rdata   (reg_rdata),
        .tx_byte     (tx_byte),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd)
    );

    // interrupt pin at configured polarity, registered
    always_ff @(posedge clk) begin
        if (!rst_n) spi_irq <= ~cfg_irq_high;
        else        spi_irq <= cfg_irq_high ? irq_req : ~irq_req;
    end
endmodule

// File: rtl/spi_regbridge_chk.sv
// Property checker for the serial register bridge, bound to the top.
module spi_regbridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        active,
    input logic        spi_miso,
    input logic        spi_irq,
    input logic        irq_req,
    input logic        cfg_irq_high,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [15:0] reg_addr
);
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd}));

    assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |=> (reg_addr == $past(reg_addr) + 16'd1));

    assert_miso_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> !spi_miso);

    assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (spi_irq == ($past(cfg_irq_high) ? $past(irq_req) : !$past(irq_req))));
endmodule

bind spi_regbridge spi_regbridge_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .spi_miso    (spi_miso),
    .spi_irq     (spi_irq),
    .irq_req     (irq_req),
    .cfg_irq_high(cfg_irq_high),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr)
);

// File: tb/spi_regbridge_tb_top.sv
`timescale 1ns/1ps
module spi_regbridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel_high = 1'b0;
    logic        cfg_irq_high = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_ext_addr = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_sel = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_irq;
    logic        irq_req = 1'b0;
    logic        active;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_wr;
    logic        reg_rd;
    logic [7:0]  reg_rdata = 8'h00;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_regbridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_sel_high(cfg_sel_high), .cfg_irq_high(cfg_irq_high),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_ext_addr(cfg_ext_addr),
        .spi_sclk(spi_sclk), .spi_sel(spi_sel), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_irq(spi_irq), .irq_req(irq_req),
        .active(active), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    // register file model with strobe logs
    logic [7:0]  mem [256];
    logic [15:0] wr_a [64];
    logic [7:0]  wr_d [64];
    logic [15:0] rd_a [64];
    int wr_n = 0;
    int rd_n = 0;
    int both_n = 0;

    function automatic logic [7:0] pat(input logic [7:0] a);
        return 8'(a * 8'd7 + 8'd3);
    endfunction

    initial for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));

    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_wr && reg_rd) both_n <= both_n + 1;
            if (reg_wr) begin
                mem[reg_addr[7:0]] <= reg_wdata;
                wr_a[wr_n % 64] <= reg_addr;
                wr_d[wr_n % 64] <= reg_wdata;
                wr_n <= wr_n + 1;
            end
            if (reg_rd) begin
                reg_rdata <= mem[reg_addr[7:0]];
                rd_a[rd_n % 64] <= reg_addr;
                rd_n <= rd_n + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // serial master
    logic [7:0] tx_q [16];
    logic [7:0] rx_q [16];

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            if (!cfg_cpha) begin
                spi_mosi = tx[7-i];
                half();
                rx = {rx[6:0], spi_miso};
                spi_sclk = ~spi_sclk;
                half();
                spi_sclk = ~spi_sclk;
            end else begin
                spi_sclk = ~spi_sclk;
                spi_mosi = tx[7-i];
                half();
                rx = {rx[6:0], spi_miso};
                spi_sclk = ~spi_sclk;
                half();
            end
        end
    endtask

    task automatic run_frame(input int nfull, input int tail);
        logic [7:0] rx;
        spi_sel = cfg_sel_high;
        half();
        for (int i = 0; i < nfull; i++) begin
            xfer(tx_q[i], 8, rx);
            rx_q[i] = rx;
        end
        if (tail > 0) xfer(tx_q[nfull], tail, rx);
        half();
        spi_sel = ~cfg_sel_high;
        repeat (10) @(negedge clk);
    endtask

    task automatic put_hdr(input logic ext, input logic [15:0] a, input logic [2:0] cmd, output int n);
        tx_q[0] = a[12:5];
        if (ext) begin
            tx_q[1] = {a[4:0], 3'b110};
            tx_q[2] = {a[15:13], cmd, 2'b00};
            n = 3;
        end else begin
            tx_q[1] = {a[4:0], cmd};
            n = 2;
        end
    endtask

    task automatic set_cfg(input logic pol, input logic pha, input logic ext, input logic selh);
        @(negedge clk);
        cfg_cpol = pol;
        cfg_cpha = pha;
        cfg_ext_addr = ext;
        cfg_sel_high = selh;
        spi_sel = ~selh;
        spi_sclk = pol;
        repeat (12) @(negedge clk);
    endtask

    // scenarios
    task automatic t_reset();
        check("R1 active idle", active, 0);
        check("R7 miso idle", spi_miso, 0);
        check("R9 irq idle low-active", spi_irq, 1);
        check("R11 strobes idle", {reg_wr, reg_rd}, 0);
    endtask

    task automatic t_write(input logic ext, input logic [15:0] a, input int nd, input logic [7:0] seed);
        int n;
        int w0 = wr_n;
        int r0 = rd_n;
        put_hdr(ext, a, 3'b100, n);
        for (int i = 0; i < nd; i++) tx_q[n+i] = 8'(seed + 8'(i * 37));
        run_frame(n + nd, 0);
        check("R4 write count", wr_n - w0, nd);
        check("R4 no reads in write", rd_n - r0, 0);
        for (int i = 0; i < nd; i++) begin
            check(ext ? "R3 ext write addr" : "R2 R4 write addr", wr_a[(w0+i)%64], a + 16'(i));
            check("R4 write data", wr_d[(w0+i)%64], tx_q[n+i]);
        end
        for (int i = 0; i < n + nd; i++) check("R7 miso zero in write", rx_q[i], 0);
    endtask

    task automatic t_read(input logic ext, input logic [15:0] a, input int nd, input string tag);
        int n;
        int r0 = rd_n;
        int w0 = wr_n;
        put_hdr(ext, a, 3'b010, n);
        for (int i = 0; i < nd; i++) tx_q[n+i] = 8'hFF;
        run_frame(n + nd, 0);
        check({tag, " R6 first read addr"}, rd_a[r0 % 64], a);
        check({tag, " R6 read strobes"}, rd_n - r0, nd + 1);
        check({tag, " R6 no writes"}, wr_n - w0, 0);
        for (int i = 0; i < n; i++) check({tag, " R7 hdr miso zero"}, rx_q[i], 0);
        for (int i = 0; i < nd; i++) check({tag, " R6 R8 read data"}, rx_q[n+i], mem[8'(a[7:0] + 8'(i))]);
    endtask

    task automatic t_noop(input logic ext, input logic [2:0] b1cmd, input logic [2:0] cmd, input string tag);
        int w0 = wr_n;
        int r0 = rd_n;
        tx_q[0] = 8'h12;
        tx_q[1] = {5'h05, b1cmd};
        tx_q[2] = ext ? {3'b001, cmd, 2'b00} : 8'h5A;
        tx_q[3] = 8'hA5;
        tx_q[4] = 8'h3C;
        run_frame(5, 0);
        check({tag, " no write"}, wr_n - w0, 0);
        check({tag, " no read"}, rd_n - r0, 0);
    endtask

    task automatic t_partial();
        int n;
        int w0 = wr_n;
        put_hdr(1'b0, 16'h0010, 3'b100, n);
        tx_q[n] = 8'h6E;
        tx_q[n+1] = 8'hF0;
        run_frame(n + 1, 5);
        check("R5 one write only", wr_n - w0, 1);
        check("R5 kept byte", wr_d[w0 % 64], 8'h6E);
    endtask

    task automatic t_abort();
        tx_q[0] = 8'hFF;
        tx_q[1] = 8'hFF;
        run_frame(1, 3);
        t_write(1'b0, 16'h0033, 1, 8'h77);
        check("R10 fresh header addr", wr_a[(wr_n-1) % 64], 16'h0033);
    endtask

    task automatic t_sel_high();
        set_cfg(1'b0, 1'b0, 1'b0, 1'b1);
        check("R1 inactive with pin low", active, 0);
        spi_sel = 1'b1;
        repeat (8) @(negedge clk);
        check("R1 active with pin high", active, 1);
        spi_sel = 1'b0;
        repeat (8) @(negedge clk);
        check("R1 released", active, 0);
        t_write(1'b0, 16'h0099, 2, 8'h4D);
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        spi_sel = 1'b1;
        repeat (8) @(negedge clk);
        check("R1 active-low pin high idle", active, 0);
    endtask

    task automatic t_irq();
        irq_req = 1'b1;
        repeat (8) @(negedge clk);
        check("R9 low-active asserted", spi_irq, 0);
        cfg_irq_high = 1'b1;
        repeat (8) @(negedge clk);
        check("R9 high-active asserted", spi_irq, 1);
        irq_req = 1'b0;
        repeat (8) @(negedge clk);
        check("R9 high-active idle", spi_irq, 0);
        cfg_irq_high = 1'b0;
        repeat (8) @(negedge clk);
        check("R9 low-active idle", spi_irq, 1);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_write(1'b0, 16'h0123, 3, 8'hAA);
        t_read(1'b0, 16'h0040, 3, "mode0");
        set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
        t_read(1'b0, 16'h1A48, 3, "mode1");
        t_write(1'b0, 16'h0180, 2, 8'h91);
        t_read(1'b0, 16'h0180, 2, "mode1 readback");
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        t_read(1'b0, 16'h0050, 2, "mode2");
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
        t_read(1'b0, 16'h0A58, 4, "mode3");
        t_read(1'b0, 16'h0064, 0, "zero-length");
        set_cfg(1'b0, 1'b0, 1'b1, 1'b0);
        t_write(1'b1, 16'hA0F1, 2, 8'h2B);
        t_read(1'b1, 16'h6042, 2, "R3 ext");
        t_noop(1'b1, 3'b100, 3'b100, "R3 bad ext marker");
        t_noop(1'b1, 3'b110, 3'b000, "R3 ext nop");
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        t_noop(1'b0, 3'b000, 3'b000, "R2 nop");
        t_noop(1'b0, 3'b011, 3'b000, "R2 unknown cmd");
        t_partial();
        t_abort();
        t_sel_high();
        t_irq();
        check("R11 strobes never together", both_n, 0);
        done = 1'b1;
        finish_run();
    end
endmodule